// File: doc/BRIEF.md
# Calendar Time-of-Day Counter

This block keeps a calendar clock made of seven byte-wide fields: seconds, minutes, hours, weekday, day of month, month and a two-digit year. A one-cycle strobe at 1 Hz advances an internal binary copy of the time. After each advance the block raises an update-in-progress flag for a fixed number of clock cycles. It then copies the new time, encoded for software, into the fields that software can see.

Software uses a simple byte port to read and write the seven fields and two control bytes. The control bytes choose BCD or binary encoding, 12-hour or 24-hour hours, an oscillator mode and a freeze mode for setting the clock. A single-cycle completion strobe goes to the interrupt logic at the end of each update window.

Top module: `rtc_tod_counter`

## Requirements
- R1: After reset, control A reads 0x26, control B reads 0x02, index 9 reads 0x00 and index 10 reads 0x80. The fields read as time 00:00:00, weekday 01 and date 01/01/00. The byte indices are: 0 seconds, 1 minutes, 2 hours, 3 weekday, 4 day of month, 5 month, 6 year, 7 control A, 8 control B.
- R2: A 1 Hz strobe advances the time by one second only while control A bits 6:4 equal 010. With any other value the strobe leaves the time unchanged.
- R3: Control A bit 7 reads 1 from the clock edge that takes a counting strobe until the end of an update window of UIP_CYCLES cycles. At that point the visible fields take the new time and the bit drops. Software writes to bit 7 are ignored.
- R4: `upd_done` is a one-cycle pulse at the end of each update window when control B bit 4 is 1. It stays low when bit 4 is 0.
- R5: When control B bit 2 is 1, all fields are plain binary. When it is 0, all fields are packed BCD, with the tens digit in bits 7:4.
- R6: When control B bit 1 is 1, the hour field holds 0–23. When it is 0, the hour field holds the hour modulo 12 and bit 7 is set for hours 12–23.
- R7: Seconds carry into minutes at 59, minutes carry into hours at 59, and hours carry into the day at 23. The weekday counts 1 to 7 and then returns to 1.
- R8: The day of month returns to 1 after 30 in April, June, September and November, and after 31 in the other long months. In February it returns after 29 when the year is divisible by 4, otherwise after 28.
- R9: The month counts 1 to 12. The year counts 0 to 99 and then wraps to 0.
- R10: While control B bit 7 is 1, the visible fields hold their values, the flag in control A bit 7 reads 0 and no `upd_done` is issued. Writing control B with bit 7 set also clears bit 4 of the stored value.
- R11: Clearing control B bit 7 loads the visible fields into the counter. Outside freeze mode, a write to any time field loads the counter immediately. Loading decodes the fields using the control B value just written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_1hz | input | 1 | One-cycle strobe, once per second |
| wr_en | input | 1 | Register write strobe |
| addr | input | AW | Register index for reads and writes |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` (combinational) |
| upd_done | output | 1 | End-of-update pulse to the interrupt logic |

## Verification
The hardest case to reach is a full carry chain through every field in one strobe, which would take centuries of real ticks. The bench reaches it through freeze mode. It writes the control byte with bit 7 set, loads all seven fields with values one second before a boundary, and then clears bit 7 so that the counter picks them up. A single strobe then tests the year wrap, a leap or non-leap February, a 30-day month and the 12-hour noon and midnight crossings. A scoreboard compares each result with a model computed in the bench, taking one sample after each end-of-update pulse.

// File: rtl/rtc_tod_counter.sv
module rtc_tod_counter #(
  parameter int UIP_CYCLES = 4,
  parameter int AW         = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_1hz,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata,
  output logic          upd_done
);
  localparam int        CW    = $clog2(UIP_CYCLES + 1);
  localparam [AW-1:0]   IDX_A = AW'(7);
  localparam [AW-1:0]   IDX_B = AW'(8);
  localparam [AW-1:0]   IDX_C = AW'(9);
  localparam [AW-1:0]   IDX_D = AW'(10);

  function automatic logic [7:0] enc(input logic [6:0] v, input logic bin);
    logic [6:0] t, o;
    t = v / 7'd10;
    o = v % 7'd10;
    return bin ? {1'b0, v} : {t[3:0], o[3:0]};
  endfunction

  function automatic logic [6:0] dec(input logic [7:0] v, input logic bin);
    return bin ? v[6:0] : 7'(7'(v[7:4]) * 7'd10 + 7'(v[3:0]));
  endfunction

  logic [6:0]    t_q   [7];
  logic [7:0]    vis_q [7];
  logic [6:0]    a_q;
  logic          uip_q;
  logic [7:0]    b_q;
  logic [CW-1:0] cnt_q;

  wire wr_time = wr_en && (addr < AW'(7));
  wire wr_a    = wr_en && (addr == IDX_A);
  wire wr_b    = wr_en && (addr == IDX_B);
  wire adv     = tick_1hz && (a_q[6:4] == 3'b010);
  wire win_end = (cnt_q == CW'(1));

  logic [7:0] b_nx;
  assign b_nx = wr_b ? (wdata[7] ? (wdata & 8'hEF) : wdata) : b_q;

  wire load = (wr_time && !b_q[7]) || (wr_b && b_q[7] && !wdata[7]);

  logic [7:0] vis_w [7];
  logic [6:0] d     [7];
  logic [6:0] hdec;
  always_comb begin
    for (int i = 0; i < 7; i++) begin
      vis_w[i] = (wr_en && addr == AW'(i)) ? wdata : vis_q[i];
      d[i]     = dec(vis_w[i], b_nx[2]);
    end
    hdec = dec({1'b0, vis_w[2][6:0]}, b_nx[2]);
    if (!b_nx[1]) d[2] = hdec + (vis_w[2][7] ? 7'd12 : 7'd0);
  end

  logic [6:0] mlen;
  logic       sw, mw, hw, dw, mnw;
  logic [6:0] nt [7];
  always_comb begin
    case (t_q[5])
      7'd2:                      mlen = (t_q[6][1:0] == 2'b00) ? 7'd29 : 7'd28;
      7'd4, 7'd6, 7'd9, 7'd11:   mlen = 7'd30;
      default:                   mlen = 7'd31;
    endcase
    sw  = t_q[0] >= 7'd59;
    mw  = sw && t_q[1] >= 7'd59;
    hw  = mw && t_q[2] >= 7'd23;
    dw  = hw && t_q[4] >= mlen;
    mnw = dw && t_q[5] >= 7'd12;
    nt[0] = sw ? 7'd0 : t_q[0] + 7'd1;
    nt[1] = !sw  ? t_q[1] : (mw ? 7'd0 : t_q[1] + 7'd1);
    nt[2] = !mw  ? t_q[2] : (hw ? 7'd0 : t_q[2] + 7'd1);
    nt[3] = !hw  ? t_q[3] : (t_q[3] >= 7'd7 ? 7'd1 : t_q[3] + 7'd1);
    nt[4] = !hw  ? t_q[4] : (dw ? 7'd1 : t_q[4] + 7'd1);
    nt[5] = !dw  ? t_q[5] : (mnw ? 7'd1 : t_q[5] + 7'd1);
    nt[6] = !mnw ? t_q[6] : (t_q[6] >= 7'd99 ? 7'd0 : t_q[6] + 7'd1);
  end

  logic [6:0] hr12;
  logic [7:0] eh;
  logic [7:0] e [7];
  always_comb begin
    for (int i = 0; i < 7; i++) e[i] = enc(t_q[i], b_q[2]);
    hr12 = (t_q[2] >= 7'd12) ? t_q[2] - 7'd12 : t_q[2];
    eh   = enc(hr12, b_q[2]);
    if (!b_q[1]) e[2] = {t_q[2] >= 7'd12, eh[6:0]};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      t_q      <= '{7'd0, 7'd0, 7'd0, 7'd1, 7'd1, 7'd1, 7'd0};
      vis_q    <= '{8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00};
      a_q      <= 7'h26;
      b_q      <= 8'h02;
      uip_q    <= 1'b0;
      cnt_q    <= '0;
      upd_done <= 1'b0;
    end else begin
      upd_done <= 1'b0;
      if (load)     t_q <= d;
      else if (adv) t_q <= nt;
      if (b_nx[7]) begin
        cnt_q <= '0;
        uip_q <= 1'b0;
      end else if (adv) begin
        cnt_q <= CW'(UIP_CYCLES);
        uip_q <= 1'b1;
      end else if (cnt_q != '0) begin
        cnt_q <= cnt_q - CW'(1);
        if (win_end) begin
          uip_q    <= 1'b0;
          upd_done <= b_q[4];
          vis_q    <= e;
        end
      end
      for (int i = 0; i < 7; i++)
        if (wr_en && addr == AW'(i)) vis_q[i] <= wdata;
      if (wr_a) a_q <= wdata[6:0];
      b_q <= b_nx;
    end
  end

  always_comb begin
    if (addr < AW'(7))       rdata = vis_q[addr[2:0]];
    else if (addr == IDX_A)  rdata = {uip_q, a_q};
    else if (addr == IDX_B)  rdata = b_q;
    else if (addr == IDX_C)  rdata = 8'h00;
    else if (addr == IDX_D)  rdata = 8'h80;
    else                     rdata = 8'h00;
  end
endmodule

// File: rtl/rtc_tod_checker.sv
module rtc_tod_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic       upd_done,
  input logic       uip,
  input logic       setm,
  input logic [2:0] osc,
  input logic [6:0] sec_int,
  input logic [7:0] sec_vis
);
  a_r10_uip_low_in_set: assert property (@(posedge clk) disable iff (!rst_n)
    setm |-> !uip);
  a_r10_vis_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (setm && !wr_en) |=> $stable(sec_vis));
  a_r4_done_after_uip: assert property (@(posedge clk) disable iff (!rst_n)
    upd_done |-> $past(uip));
  a_r4_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    upd_done |=> !upd_done);
  a_r2_hold_osc_off: assert property (@(posedge clk) disable iff (!rst_n)
    (osc != 3'b010 && !wr_en) |=> $stable(sec_int));
endmodule

bind rtc_tod_counter rtc_tod_checker u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .upd_done(upd_done),
  .uip(uip_q), .setm(b_q[7]), .osc(a_q[6:4]),
  .sec_int(t_q[0]), .sec_vis(vis_q[0])
);

// File: tb/rtc_tod_counter_tb.sv
`timescale 1ns/100ps
module rtc_tod_counter_tb;
  localparam int UIPC = 4;
  logic clk = 0, rst_n = 0, tick = 0, wr_en = 0;
  logic [3:0] drv_addr = 0, mon_addr = 0, addr;
  logic mon_busy = 0;
  logic [7:0] wdata = 0, rdata;
  logic upd_done;
  int checks = 0, errors = 0;
  int m [7];
  logic [7:0] mb = 8'h02;
  logic [55:0] exp_q [$];
  string tag_q [$];

  assign addr = mon_busy ? mon_addr : drv_addr;
  always #2 clk = ~clk;

  rtc_tod_counter #(.UIP_CYCLES(UIPC), .AW(4)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick_1hz(tick), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .upd_done(upd_done));

  function automatic logic [7:0] benc(int v, bit bin);
    return bin ? 8'(v) : 8'(((v / 10) << 4) | (v % 10));
  endfunction
  function automatic logic [7:0] fenc(int i, int v, logic [7:0] mode);
    if (i == 2 && !mode[1]) return ((v >= 12) ? 8'h80 : 8'h00) | benc(v % 12, mode[2]);
    return benc(v, mode[2]);
  endfunction
  function automatic logic [55:0] exp_vec();
    logic [55:0] r;
    for (int i = 0; i < 7; i++) r[i*8 +: 8] = fenc(i, m[i], mb);
    return r;
  endfunction
  function automatic int mdays(int mo, int yr);
    if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction
  task automatic model_step();
    m[0]++;
    if (m[0] == 60) begin m[0] = 0; m[1]++; end
    if (m[1] == 60) begin m[1] = 0; m[2]++; end
    if (m[2] == 24) begin
      m[2] = 0;
      m[3] = (m[3] == 7) ? 1 : m[3] + 1;
      m[4]++;
      if (m[4] > mdays(m[5], m[6])) begin m[4] = 1; m[5]++; end
      if (m[5] == 13) begin m[5] = 1; m[6] = (m[6] + 1) % 100; end
    end
  endtask

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask
  task automatic wr(int a, logic [7:0] d);
    @(negedge clk); drv_addr = 4'(a); wdata = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask
  task automatic rd(int a, output logic [7:0] v);
    @(negedge clk); drv_addr = 4'(a); #0.5; v = rdata;
  endtask
  task automatic pulse_tick();
    @(negedge clk); tick = 1;
    @(negedge clk); tick = 0;
  endtask
  task automatic drain(string req);
    for (int i = 0; i < 40 && (exp_q.size() != 0 || mon_busy); i++) @(negedge clk);
    if (exp_q.size() != 0) begin
      checks++; errors++;
      $display("FAIL %s: update never completed, got %0d pending expected 0", req, exp_q.size());
      exp_q.delete(); tag_q.delete();
    end
  endtask
  task automatic tick_expect(string req);
    model_step();
    exp_q.push_back(exp_vec()); tag_q.push_back(req);
    pulse_tick();
    drain(req);
  endtask
  task automatic set_time(logic [7:0] mode, int s, int mi, int h, int wd, int dm, int mo, int y);
    mb = mode;
    m = '{s, mi, h, wd, dm, mo, y};
    wr(8, mode | 8'h80);
    for (int i = 0; i < 7; i++) wr(i, fenc(i, m[i], mode));
    wr(8, mode);
  endtask

  initial begin
    logic [7:0] g [7];
    logic [55:0] e;
    string t;
    forever begin
      @(negedge clk);
      if (upd_done) begin
        mon_busy = 1;
        for (int i = 0; i < 7; i++) begin mon_addr = 4'(i); #0.2; g[i] = rdata; end
        if (exp_q.size() == 0) begin
          checks++; errors++;
          $display("FAIL R4: unexpected update-done, got 1 expected 0");
        end else begin
          e = exp_q.pop_front(); t = tag_q.pop_front();
          for (int i = 0; i < 7; i++) chk(t, g[i], e[i*8 +: 8]);
        end
        mon_busy = 0;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] v;
    m = '{0, 0, 0, 1, 1, 1, 0};
    repeat (3) @(negedge clk);
    rst_n = 1;
    rd(7, v);  chk("R1", v, 8'h26);
    rd(8, v);  chk("R1", v, 8'h02);
    rd(9, v);  chk("R1", v, 8'h00);
    rd(10, v); chk("R1", v, 8'h80);
    for (int i = 0; i < 7; i++) begin rd(i, v); chk("R1", v, fenc(i, m[i], 8'h02)); end

    wr(8, 8'h12); mb = 8'h12;
    model_step();
    exp_q.push_back(exp_vec()); tag_q.push_back("R2");
    pulse_tick();
    rd(7, v); chk("R3", v[7], 1'b1);
    drain("R2");
    rd(7, v); chk("R3", v[7], 1'b0);

    wr(7, 8'hA6); rd(7, v); chk("R3", v, 8'h26);

    wr(7, 8'h06); pulse_tick(); repeat (UIPC + 4) @(negedge clk);
    rd(0, v); chk("R2", v, 8'h01);
    rd(7, v); chk("R2", v, 8'h06);
    wr(7, 8'h26);

    wr(8, 8'h02); mb = 8'h02; model_step();
    pulse_tick(); repeat (UIPC + 4) @(negedge clk);
    rd(0, v); chk("R4", v, 8'h02);
    wr(8, 8'h12); mb = 8'h12;

    wr(0, 8'h30); m[0] = 30; tick_expect("R11");

    set_time(8'h12, 59, 59, 23, 7, 31, 12, 99); tick_expect("R9");
    set_time(8'h12, 59, 59, 9, 3, 15, 5, 10);   tick_expect("R7");
    set_time(8'h12, 59, 59, 23, 3, 28, 2, 4);   tick_expect("R8");
    set_time(8'h12, 59, 59, 23, 3, 28, 2, 5);   tick_expect("R8");
    set_time(8'h12, 59, 59, 23, 4, 29, 2, 0);   tick_expect("R8");
    set_time(8'h12, 59, 59, 23, 5, 30, 4, 21);  tick_expect("R8");
    set_time(8'h12, 59, 59, 23, 5, 30, 1, 21);  tick_expect("R8");

    set_time(8'h16, 59, 59, 13, 4, 15, 6, 23);  tick_expect("R5");
    set_time(8'h16, 59, 59, 23, 6, 31, 12, 99); tick_expect("R5");

    set_time(8'h10, 59, 59, 23, 2, 10, 3, 12);  tick_expect("R6");
    set_time(8'h10, 59, 59, 11, 2, 10, 3, 12);  tick_expect("R6");
    set_time(8'h14, 59, 59, 12, 2, 10, 3, 12);  tick_expect("R6");

    set_time(8'h12, 10, 20, 8, 1, 5, 7, 30);
    wr(8, 8'h92); rd(8, v); chk("R10", v, 8'h82);
    pulse_tick(); rd(7, v); chk("R10", v[7], 1'b0);
    repeat (UIPC + 4) @(negedge clk);
    rd(0, v); chk("R10", v, 8'h10);
    wr(0, 8'h05); rd(0, v); chk("R10", v, 8'h05);
    wr(8, 8'h12); m[0] = 5;
    tick_expect("R11");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule